// File: doc/BRIEF.md
# Keyed Watchdog Countdown Timer

A bus-visible watchdog that counts down from a programmed value and, when it runs out, asks the system to reset itself. Software arms it through a control word. It must keep it alive by writing a fixed 16-bit key to a kick register before the count reaches zero. A kick copies the reload value back into the counter, so a stray write with any other value cannot keep a hung system alive.

The counter steps once per microsecond. The microsecond tick comes from a prescaler on the peripheral clock. When the count runs out, the timer stops and stays at zero. It then either pulses a reset request or raises an interrupt level, as the control word selects. A hold input from the memory controller's reset logic swallows the expiry and clears the control word. This keeps the watchdog from firing into a memory reset.

Registers are 32 bits wide at byte offsets 0x00 (count, read-only), 0x04 (reload value), 0x08 (kick, write-only) and 0x0C (control). Writes take effect on the clock edge. Reads are combinational from `addr`.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the count (0x00) and the reload value (0x04) both read 0x014FB180, the control word (0x0C) reads 0x10, and `reset_req` and `irq` are low.
- R2: Reading the kick offset 0x08 or any unmapped offset returns 0. Writes to the count offset 0x00 and to unmapped offsets change no register.
- R3: A write to 0x08 whose bits 15:0 equal 0x4755 loads the reload value into the count and clears `irq`. If the control enable bit is set, it also restarts the countdown. A write to 0x08 with any other low half changes nothing.
- R4: Every control write is stored with bits 11:8 forced to 0 and bit 4 forced to 1. The control bits are: bit 0 enable, bit 1 reset-request enable, bit 2 interrupt enable, bit 3 external signal, bit 4 microsecond tick select, bits 6:5 reset mode.
- R5: A control write that takes the enable bit from 0 to 1 starts the countdown from the reload value. A control write that leaves the enable bit at 1 only stores the value and does not restart a stopped timer.
- R6: A control write that clears the enable bit stops the countdown. The count then holds, and no expiry follows.
- R7: While running, the count drops by one every PRESCALE clocks. With reload N≥1, expiry happens on the N-th tick after the start. The count then stays at 0, and the countdown does not reload by itself.
- R8: At expiry without hold, `reset_req` is high for exactly one cycle if control bit 1 is set. `irq` goes high if control bit 2 is set and stays high until a valid kick. Both outputs change on the clock edge after the expiry.
- R9: If `mem_hold` is high at expiry, the control word becomes 0, and neither `reset_req` nor `irq` is raised.
- R10: A valid kick, or a control write that starts or stops the timer, in the same cycle as an expiry takes priority. The expiry is dropped, and the countdown follows the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| mem_hold | input | 1 | Memory-controller reset hold; swallows an expiry |
| reset_req | output | 1 | One-cycle reset request at expiry |
| irq | output | 1 | Expiry interrupt level |

## Verification
Two events can land in the same cycle: a bus write and the counter reaching its final tick. The bench places a valid kick exactly on the clock edge at which a 3-tick countdown would expire. It does this by counting the clocks from the start: PRESCALE times the reload value. It then checks that no reset request or interrupt appeared, that the count reads back the reload value, and that the reloaded countdown later expires on schedule. A second overlap is `mem_hold` held high across an expiry. This is judged by the control word reading 0 and the reset-request pulse count not moving.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int          ADDR_W    = 8,
  parameter int          PRESCALE  = 24,
  parameter logic [31:0] INIT_LOAD = 32'h014F_B180,
  parameter logic [15:0] KICK_KEY  = 16'h4755
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              mem_hold,
  output logic              reset_req,
  output logic              irq
);

  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h0C);
  localparam logic [31:0] CTRL_SET = 32'h0000_0010;
  localparam logic [31:0] CTRL_CLR = 32'h0000_0F00;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic [31:0]   count_q, load_q, ctrl_q;
  logic          run_q;
  logic [PW-1:0] pre_q;

  wire wr_load = wr_en && (addr == A_LOAD);
  wire wr_kick = wr_en && (addr == A_KICK);
  wire wr_ctrl = wr_en && (addr == A_CTRL);
  wire kick_ok = wr_kick && (wdata[15:0] == KICK_KEY);

  wire [31:0] ctrl_new = (wdata & ~CTRL_CLR) | CTRL_SET;

  wire start = (wr_ctrl && ctrl_new[0] && !ctrl_q[0]) || (kick_ok && ctrl_q[0]);
  wire stop  = wr_ctrl && !ctrl_new[0] && ctrl_q[0];

  wire pre_end = (pre_q == PRE_LAST);
  wire tick    = ctrl_q[4] ? pre_end : 1'b1;
  wire last    = (count_q <= 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= INIT_LOAD;
      load_q    <= INIT_LOAD;
      ctrl_q    <= CTRL_SET;
      run_q     <= 1'b0;
      pre_q     <= '0;
      reset_req <= 1'b0;
      irq       <= 1'b0;
    end else begin
      reset_req <= 1'b0;
      if (wr_load) load_q <= wdata;
      if (wr_ctrl) ctrl_q <= ctrl_new;
      if (kick_ok) begin
        count_q <= load_q;
        irq     <= 1'b0;
      end
      if (start) begin
        run_q   <= 1'b1;
        pre_q   <= '0;
        count_q <= load_q;
      end else if (stop) begin
        run_q <= 1'b0;
        pre_q <= '0;
      end else if (run_q) begin
        pre_q <= pre_end ? '0 : pre_q + 1'b1;
        if (tick) begin
          if (last) begin
            count_q <= '0;
            run_q   <= 1'b0;
            pre_q   <= '0;
            if (mem_hold) begin
              ctrl_q <= '0;
            end else begin
              reset_req <= ctrl_q[1];
              if (ctrl_q[2]) irq <= 1'b1;
            end
          end else begin
            count_q <= count_q - 32'd1;
          end
        end
      end
    end
  end

  always_comb begin
    case (addr)
      A_CNT:   rdata = count_q;
      A_LOAD:  rdata = load_q;
      A_CTRL:  rdata = ctrl_q;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        mem_hold,
  input logic        reset_req,
  input logic        run_q,
  input logic [31:0] count_q,
  input logic [31:0] ctrl_q
);

  a_r8_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  a_r9_hold_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> !$past(mem_hold));

  a_r4_ctrl_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q != 32'd0) |-> (ctrl_q[4] && ctrl_q[11:8] == 4'd0));

  a_r6_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_en) |=> $stable(count_q));

  a_r7_stop_at_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (!run_q && count_q == 32'd0));

endmodule

bind wdog_timer wdog_timer_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .mem_hold  (mem_hold),
  .reset_req (reset_req),
  .run_q     (run_q),
  .count_q   (count_q),
  .ctrl_q    (ctrl_q)
);

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
  localparam int AW = 8;
  localparam int PS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          mem_hold = 1'b0;
  logic          reset_req;
  logic          irq;

  int tests = 0;
  int fails = 0;
  int pulses = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        rd_ev;

  always #4 clk = ~clk;

  wdog_timer #(.ADDR_W(AW), .PRESCALE(PS)) i_wdog_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .mem_hold(mem_hold), .reset_req(reset_req), .irq(irq)
  );

  always @(posedge clk) begin
    #1;
    if (reset_req) pulses++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    #2 -> rd_ev;
  endtask

  initial begin
    forever begin
      @(rd_ev);
      check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (6000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R1 reset_req low", {31'd0, reset_req}, 32'd0);
    check("R1 irq low", {31'd0, irq}, 32'd0);
    rd(8'h00, 32'h014F_B180, "R1 count reset");
    rd(8'h04, 32'h014F_B180, "R1 reload reset");
    rd(8'h0C, 32'h0000_0010, "R1 ctrl reset");
    rd(8'h08, 32'h0, "R2 kick reads zero");

    wr(8'h04, 32'd5);
    wr(8'h0C, 32'h0000_0F07);
    repeat (19) @(posedge clk);
    #1 check("R7 no expiry before tick 5", {30'd0, reset_req, irq}, 32'd0);
    @(posedge clk);
    #1 check("R8 req and irq at expiry", {30'd0, reset_req, irq}, 32'd3);
    @(posedge clk);
    #1 check("R8 req one cycle, irq held", {30'd0, reset_req, irq}, 32'd1);
    rd(8'h0C, 32'h0000_0017, "R4 sanitized ctrl");
    rd(8'h00, 32'h0, "R7 count stops at zero");
    repeat (20) @(posedge clk);
    rd(8'h00, 32'h0, "R7 no auto reload");

    wr(8'h00, 32'h0000_0123);
    rd(8'h00, 32'h0, "R2 count write ignored");
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h04, 32'd5, "R2 unmapped write reload intact");
    rd(8'h0C, 32'h0000_0017, "R2 unmapped write ctrl intact");
    rd(8'h14, 32'h0, "R2 unmapped read zero");

    wr(8'h08, 32'h0000_4756);
    rd(8'h00, 32'h0, "R3 wrong key ignored");
    check("R3 wrong key keeps irq", {31'd0, irq}, 32'd1);
    wr(8'h08, 32'hABCD_4755);
    check("R3 key clears irq", {31'd0, irq}, 32'd0);
    rd(8'h00, 32'd5, "R3 key reloads count");
    wr(8'h0C, 32'h0000_0006);
    repeat (40) @(posedge clk);
    rd(8'h00, 32'd5, "R6 count frozen after disable");
    rd(8'h0C, 32'h0000_0016, "R4 ctrl stored on disable");
    check("R6 no expiry after disable", pulses, 32'd1);

    wr(8'h0C, 32'h0000_0003);
    repeat (20) @(posedge clk);
    #1 check("R8 req without irq", {30'd0, reset_req, irq}, 32'd2);
    wr(8'h0C, 32'h0000_0005);
    repeat (40) @(posedge clk);
    rd(8'h00, 32'h0, "R5 enable 1 to 1 does not restart");
    check("R5 no irq without restart", {31'd0, irq}, 32'd0);

    wr(8'h08, 32'h0000_4755);
    repeat (20) @(posedge clk);
    #1 check("R8 irq without req", {30'd0, reset_req, irq}, 32'd1);
    check("R8 req pulse count", pulses, 32'd2);

    wr(8'h04, 32'd2);
    @(negedge clk) mem_hold = 1'b1;
    wr(8'h08, 32'h0000_4755);
    repeat (12) @(posedge clk);
    rd(8'h0C, 32'h0, "R9 hold clears ctrl");
    rd(8'h00, 32'h0, "R9 count stopped");
    check("R9 hold no irq", {31'd0, irq}, 32'd0);
    check("R9 hold no req", pulses, 32'd2);
    @(negedge clk) mem_hold = 1'b0;

    wr(8'h04, 32'd3);
    wr(8'h0C, 32'h0000_0007);
    repeat (11) @(posedge clk);
    wr(8'h08, 32'h0000_4755);
    check("R10 kick beats expiry", {30'd0, reset_req, irq}, 32'd0);
    rd(8'h00, 32'd3, "R10 count reloaded");
    repeat (12) @(posedge clk);
    #1 check("R10 later expiry on schedule", {30'd0, reset_req, irq}, 32'd3);

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule